// File: doc/BRIEF.md
# Receive Ring Writer

This block takes an incoming Ethernet frame, already accepted by the address filter, and stores it in a circular region of local packet memory built from 256-byte pages. The region is bounded by a first page and a one-past-last page, and two further page pointers come from the register bank. The current page says where the next frame goes. The boundary page marks the oldest page that software has not yet read.

When a frame starts, the block checks whether the ring is able to hold a frame of the largest legal size. If the ring cannot, or the controller is stopped, the whole frame is discarded. If the frame fits, its payload bytes are written one per beat, starting four bytes into the current page. When the write address reaches the end of the region, it wraps to the first page. After the last byte, the block fills in the four reserved bytes with a header: a status byte, the page where the next frame will start, and the stored length. It then hands the new current page back to the register bank, pulses the receive interrupt and latches the status byte. A frame that is abandoned part way through is never committed.

The input is a byte stream with start, end and abandon markers and a flag saying whether the destination address is a group address. The output is a single byte-write port into packet memory. Frames must be spaced at least five cycles apart, which leaves room for the header writes.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, no memory write, current-page update or interrupt pulse is driven, and the latched status reads 0x00.
- R2: A frame whose first beat arrives while `rx_stopped` is high produces no memory write and no current-page update.
- R3: When the stop page is not greater than the start page, the ring counts as full, and every frame is dropped without any write.
- R4: Free bytes equal boundary minus current when current < boundary, and (stop − start) − (current − boundary) otherwise, with each page pointer taken as page×256. A frame is dropped when free bytes are below 1518. It is accepted at or above 1518.
- R5: Payload byte k of an accepted frame is written on the cycle after its beat, to address index+4+k, where index is the current page ×256. Idle beats in between are skipped.
- R6: A payload write address that would equal stop×256 becomes start×256 instead.
- R7: After the last payload byte, the four header bytes are written to index+0..3 on consecutive cycles. They are: status, which is 0x01, or 0x21 when the group flag was high on the first beat; then the next page; then the length (frame size + 4) low byte; then its high byte.
- R8: The next page is (index + ((size + 8 + 255) rounded down to a multiple of 256)) / 256. Stop − start pages are subtracted when the result reaches or passes the stop page.
- R9: On the cycle of the last header write, `cur_upd` and `rx_irq` pulse for one cycle. `cur_next` carries the next page, and `rx_status` holds the status byte from then on.
- R10: When the current page is at or beyond the end of packet memory (parameter, 128 pages by default), the frame is written from the start page. The fit test still uses the raw current page.
- R11: Raising `in_abort` during an accepted frame ends it with no header, no current-page update and no interrupt. Any payload bytes already written stay where they are.
- R12: A frame with a single beat, carrying both start and end markers, is stored with length 5 and advances the current page by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_stopped | input | 1 | Controller stopped; frames are discarded |
| ring_start_pg | input | 8 | First page of the receive ring |
| ring_stop_pg | input | 8 | Page one past the end of the ring |
| ring_bnd_pg | input | 8 | Boundary page (oldest unread page) |
| ring_cur_pg | input | 8 | Current page where the next frame goes |
| in_valid | input | 1 | A data byte is present this cycle |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_abort | input | 1 | Abandon the frame in progress |
| in_data | input | 8 | Frame byte |
| in_group | input | 1 | Destination address is a group address (sampled on first beat) |
| mem_we | output | 1 | Packet memory byte write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_upd | output | 1 | One-cycle pulse: load `cur_next` into the current page |
| cur_next | output | 8 | New current page value |
| rx_irq | output | 1 | One-cycle receive-done interrupt pulse |
| rx_status | output | 8 | Status byte of the last committed frame |

## Verification
Frames of 60 and 64 bytes, with individual and group destinations, check the header status byte and a one-page advance. Lengths of 248 and 249 bytes sit on either side of the page-rounding step and separate a one-page advance from a two-page advance. A 300-byte frame starting in the last page of the ring shows both the payload wrap and the subtraction in the next-page arithmetic. Fit tests are placed at exactly 1280 and 1536 free bytes under both free-space branches, and further cases cover a stopped controller, an empty region, a current page beyond memory, a one-beat frame, a stream with idle bubbles, and an abandoned frame whose partial payload must appear while its header and update must not.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int HDR_BYTES  = 4;
    localparam int CRC_BYTES  = 4;
    localparam int PAGE_BYTES = 256;

    localparam logic [7:0] ST_GOOD  = 8'h01;
    localparam logic [7:0] ST_GROUP = 8'h20;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RECV,
        S_DROP,
        S_HDR
    } rx_state_t;

    typedef struct packed {
        logic [7:0]  status;
        logic [7:0]  next_pg;
        logic [15:0] total;
    } rx_hdr_t;

    // Ring holds fewer free bytes than a worst-case frame plus its header.
    function automatic logic ring_is_full(input int start_b, input int stop_b,
                                          input int bnd_b, input int cur_b,
                                          input int max_frame);
        int avail;
        if (stop_b <= start_b) begin
            return 1'b1;
        end
        if (cur_b < bnd_b) begin
            avail = bnd_b - cur_b;
        end else begin
            avail = (stop_b - start_b) - (cur_b - bnd_b);
        end
        return (avail < max_frame + HDR_BYTES);
    endfunction

    // Byte address of the page that follows a stored frame.
    function automatic int next_ring_addr(input int base_b, input int frm_len,
                                          input int start_b, input int stop_b);
        int nxt;
        nxt = base_b + ((frm_len + HDR_BYTES + CRC_BYTES + PAGE_BYTES - 1)
                        & ~(PAGE_BYTES - 1));
        if (nxt >= stop_b) begin
            nxt = nxt - (stop_b - start_b);
        end
        return nxt;
    endfunction

    function automatic logic [7:0] hdr_byte(input rx_hdr_t h, input logic [1:0] sel);
        logic [7:0] b;
        case (sel)
            2'd0:    b = h.status;
            2'd1:    b = h.next_pg;
            2'd2:    b = h.total[7:0];
            default: b = h.total[15:8];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rxr_fit_check.sv
module rxr_fit_check #(
    parameter int PAGE_W     = 8,
    parameter int ADDR_W     = PAGE_W + 8,
    parameter int MEM_END_PG = 128,
    parameter int MAX_FRAME  = 1514
) (
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [PAGE_W-1:0] bnd_pg,
    input  logic [PAGE_W-1:0] cur_pg,
    output logic              full,
    output logic [ADDR_W-1:0] idx_b
);
    import rxr_pkg::*;

    int start_b, stop_b, bnd_b, cur_b;

    always_comb begin
        start_b = int'(start_pg) * PAGE_BYTES;
        stop_b  = int'(stop_pg)  * PAGE_BYTES;
        bnd_b   = int'(bnd_pg)   * PAGE_BYTES;
        cur_b   = int'(cur_pg)   * PAGE_BYTES;
        full    = ring_is_full(start_b, stop_b, bnd_b, cur_b, MAX_FRAME);
        // a current page beyond packet memory restarts at the ring start
        if (int'(cur_pg) >= MEM_END_PG) begin
            idx_b = ADDR_W'(start_b);
        end else begin
            idx_b = ADDR_W'(cur_b);
        end
    end

endmodule

// File: rtl/rxr_next_calc.sv
module rxr_next_calc #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = PAGE_W + 8,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] base_b,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic [PAGE_W-1:0] next_pg
);
    import rxr_pkg::*;

    int nxt_b;

    always_comb begin
        nxt_b   = next_ring_addr(int'(base_b), int'(frm_len),
                                 int'(start_pg) * PAGE_BYTES,
                                 int'(stop_pg) * PAGE_BYTES);
        next_pg = PAGE_W'(nxt_b / PAGE_BYTES);
    end

endmodule

// File: rtl/rxr_byte_pointer.sv
module rxr_byte_pointer #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = PAGE_W + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              active,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_inc
);
    logic [ADDR_W-1:0] plus1;
    logic [ADDR_W-1:0] stop_b;
    logic [ADDR_W-1:0] start_b;

    assign stop_b  = {stop_pg, 8'h00};
    assign start_b = {start_pg, 8'h00};
    assign plus1   = ptr + ADDR_W'(1);
    assign ptr_inc = (plus1 == stop_b) ? start_b : plus1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_addr;
        end else if (step) begin
            ptr <= ptr_inc;
        end
    end

    // R6
    ptr_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (ptr != stop_b));

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
    parameter int PAGE_W     = 8,
    parameter int LEN_W      = 16,
    parameter int MEM_END_PG = 128,
    parameter int MAX_FRAME  = 1514
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_stopped,
    input  logic [7:0]  ring_start_pg,
    input  logic [7:0]  ring_stop_pg,
    input  logic [7:0]  ring_bnd_pg,
    input  logic [7:0]  ring_cur_pg,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_abort,
    input  logic [7:0]  in_data,
    input  logic        in_group,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        cur_upd,
    output logic [7:0]  cur_next,
    output logic        rx_irq,
    output logic [7:0]  rx_status
);
    import rxr_pkg::*;

    localparam int ADDR_W = PAGE_W + 8;

    rx_state_t         state;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              grp_q;
    logic [1:0]        hsel_q;

    logic              ring_full;
    logic [ADDR_W-1:0] idx_b;
    logic [ADDR_W-1:0] first_b;
    logic [ADDR_W-1:0] ptr_cur;
    logic [ADDR_W-1:0] ptr_inc;
    logic [PAGE_W-1:0] nxt_pg;
    logic              sof_hit;
    logic              accept;
    logic              ptr_step;
    logic              recv_act;
    rx_hdr_t           hdr;

    rxr_fit_check #(
        .PAGE_W    (PAGE_W),
        .ADDR_W    (ADDR_W),
        .MEM_END_PG(MEM_END_PG),
        .MAX_FRAME (MAX_FRAME)
    ) u_fit (
        .start_pg(ring_start_pg),
        .stop_pg (ring_stop_pg),
        .bnd_pg  (ring_bnd_pg),
        .cur_pg  (ring_cur_pg),
        .full    (ring_full),
        .idx_b   (idx_b)
    );

    rxr_next_calc #(
        .PAGE_W(PAGE_W),
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) u_next (
        .base_b  (base_q),
        .frm_len (cnt_q),
        .start_pg(ring_start_pg),
        .stop_pg (ring_stop_pg),
        .next_pg (nxt_pg)
    );

    rxr_byte_pointer #(
        .PAGE_W(PAGE_W),
        .ADDR_W(ADDR_W)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_addr(first_b),
        .step     (ptr_step),
        .active   (recv_act),
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .ptr      (ptr_cur),
        .ptr_inc  (ptr_inc)
    );

    assign sof_hit  = (state == S_IDLE) && in_valid && in_sof;
    assign accept   = sof_hit && !rx_stopped && !ring_full;
    assign first_b  = idx_b + ADDR_W'(HDR_BYTES);
    assign recv_act = (state == S_RECV);
    assign ptr_step = recv_act && !in_abort && in_valid;

    always_comb begin
        hdr.status  = ST_GOOD | (grp_q ? ST_GROUP : 8'h00);
        hdr.next_pg = 8'(nxt_pg);
        hdr.total   = 16'(int'(cnt_q) + HDR_BYTES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            base_q    <= '0;
            cnt_q     <= '0;
            grp_q     <= 1'b0;
            hsel_q    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            cur_upd   <= 1'b0;
            cur_next  <= '0;
            rx_irq    <= 1'b0;
            rx_status <= '0;
        end else begin
            mem_we  <= 1'b0;
            cur_upd <= 1'b0;
            rx_irq  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (sof_hit) begin
                        if (!accept) begin
                            state <= in_eof ? S_IDLE : S_DROP;
                        end else begin
                            base_q    <= idx_b;
                            grp_q     <= in_group;
                            cnt_q     <= LEN_W'(1);
                            hsel_q    <= '0;
                            mem_we    <= 1'b1;
                            mem_addr  <= 16'(first_b);
                            mem_wdata <= in_data;
                            state     <= in_eof ? S_HDR : S_RECV;
                        end
                    end
                end
                S_RECV: begin
                    if (in_abort) begin
                        state <= S_IDLE;
                    end else if (in_valid) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= 16'(ptr_inc);
                        mem_wdata <= in_data;
                        cnt_q     <= cnt_q + LEN_W'(1);
                        if (in_eof) begin
                            hsel_q <= '0;
                            state  <= S_HDR;
                        end
                    end
                end
                S_DROP: begin
                    if (in_abort || (in_valid && in_eof)) begin
                        state <= S_IDLE;
                    end
                end
                S_HDR: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= 16'(base_q + ADDR_W'(hsel_q));
                    mem_wdata <= hdr_byte(hdr, hsel_q);
                    hsel_q    <= hsel_q + 2'd1;
                    if (hsel_q == 2'd3) begin
                        cur_upd   <= 1'b1;
                        cur_next  <= 8'(nxt_pg);
                        rx_irq    <= 1'b1;
                        rx_status <= hdr.status;
                        state     <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    stopped_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sof_hit && rx_stopped) |=> !mem_we);

    // R3
    empty_ring_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sof_hit && (ring_stop_pg <= ring_start_pg)) |=> !mem_we);

    // R11
    abort_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (recv_act && in_abort) |=> (!cur_upd && !mem_we));

    // R9
    commit_signals_chk: assert property (@(posedge clk) disable iff (rst)
        cur_upd |-> (rx_irq && mem_we && rx_status[0]));

    // R8
    next_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        cur_upd |-> ((cur_next >= ring_start_pg) && (cur_next < ring_stop_pg)));

endmodule

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;

    localparam int END_PG = 128;
    localparam int MAXF   = 1514;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        stopped;
    logic [7:0]  st, sp, bd, cu;
    logic        in_valid, in_sof, in_eof, in_abort, in_group;
    logic [7:0]  in_data;
    logic        mem_we, cur_upd, rx_irq;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_next, rx_status;

    rx_ring_writer u0 (
        .clk(clk), .rst(rst), .rx_stopped(stopped),
        .ring_start_pg(st), .ring_stop_pg(sp), .ring_bnd_pg(bd), .ring_cur_pg(cu),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort),
        .in_data(in_data), .in_group(in_group),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_upd(cur_upd), .cur_next(cur_next), .rx_irq(rx_irq), .rx_status(rx_status)
    );

    int    checks = 0;
    int    errors = 0;
    int    wr_seen = 0;
    int    upd_seen = 0;
    bit    done = 0;

    int    q_addr[$];
    int    q_data[$];
    string q_tag[$];
    int    q_pg[$];
    int    q_st[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                wr_seen++;
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R2", "unexpected write", int'(mem_addr), 0);
                end else begin
                    int    ea;
                    int    ed;
                    string et;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    et = q_tag.pop_front();
                    chk(int'(mem_addr) == ea, et, "write address", int'(mem_addr), ea);
                    chk(int'(mem_wdata) == ed, et, "write data", int'(mem_wdata), ed);
                end
            end
            if (cur_upd) begin
                upd_seen++;
                if (q_pg.size() == 0) begin
                    chk(1'b0, "R11", "unexpected update", int'(cur_next), 0);
                end else begin
                    int ep;
                    int es;
                    ep = q_pg.pop_front();
                    es = q_st.pop_front();
                    chk(int'(cur_next) == ep, "R8", "next page", int'(cur_next), ep);
                    chk(rx_irq == 1'b1, "R9", "irq pulse", int'(rx_irq), 1);
                    chk(int'(rx_status) == es, "R9", "status latch", int'(rx_status), es);
                end
                cu = cur_next;
            end
        end
    end

    function automatic bit model_full(input int c);
        int s, e, b, x, avail;
        s = int'(st) * 256; e = int'(sp) * 256; b = int'(bd) * 256; x = c * 256;
        if (e <= s) return 1'b1;
        if (x < b) avail = b - x;
        else       avail = (e - s) - (x - b);
        return avail < MAXF + 4;
    endfunction

    task automatic push_wr(input int a, input int d, input string t);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(t);
    endtask

    // driver: predicts writes, then streams the frame
    task automatic send(input int len, input bit grp, input int seed,
                        input int abort_at, input bit bubbles, input string tag);
        int  cur0, w0, u0c, idx, addr, nxt, n, stat;
        bit  take, wrapped;
        cur0 = int'(cu);
        w0   = wr_seen;
        u0c  = upd_seen;
        take = !stopped && !model_full(cur0);
        idx  = (cur0 >= END_PG) ? int'(st) * 256 : cur0 * 256;
        if (take) begin
            n = (abort_at >= 0) ? abort_at : len;
            addr = idx + 4;
            wrapped = 1'b0;
            for (int k = 0; k < n; k++) begin
                push_wr(addr, (seed + k * 13) & 8'hFF, wrapped ? "R6" : tag);
                addr++;
                if (addr == int'(sp) * 256) begin
                    addr = int'(st) * 256;
                    wrapped = 1'b1;
                end
            end
            if (abort_at < 0) begin
                nxt = idx + ((len + 8 + 255) & ~255);
                if (nxt >= int'(sp) * 256) nxt -= (int'(sp) - int'(st)) * 256;
                stat = grp ? 8'h21 : 8'h01;
                push_wr(idx,     stat,                "R7");
                push_wr(idx + 1, nxt / 256,           "R7");
                push_wr(idx + 2, (len + 4) & 8'hFF,   "R7");
                push_wr(idx + 3, (len + 4) / 256,     "R7");
                q_pg.push_back(nxt / 256);
                q_st.push_back(stat);
            end
        end
        for (int k = 0; k < len; k++) begin
            if (abort_at >= 0 && k == abort_at) begin
                in_valid = 1'b0;
                in_abort = 1'b1;
                @(negedge clk);
                in_abort = 1'b0;
                break;
            end
            if (bubbles && (k % 5 == 2)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sof   = (k == 0);
            in_eof   = (k == len - 1);
            in_data  = 8'((seed + k * 13) & 8'hFF);
            in_group = grp;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_group = 1'b0;
        repeat (8) @(negedge clk);
        chk(q_addr.size() == 0, tag, "writes still pending", q_addr.size(), 0);
        if (!take) begin
            chk(wr_seen == w0, tag, "writes on dropped frame", wr_seen - w0, 0);
            chk(int'(cu) == cur0, tag, "current page after drop", int'(cu), cur0);
        end else if (abort_at >= 0) begin
            chk(upd_seen == u0c, "R11", "update after abort", upd_seen - u0c, 0);
            chk(int'(cu) == cur0, "R11", "current page after abort", int'(cu), cur0);
        end else begin
            chk(upd_seen == u0c + 1, "R9", "one update per frame", upd_seen - u0c, 1);
        end
    endtask

    initial begin
        rst = 1'b1; stopped = 1'b0;
        st = 8'h40; sp = 8'h60; bd = 8'h40; cu = 8'h40;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
        in_data = 8'h00; in_group = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_we == 1'b0, "R1", "mem_we after reset", int'(mem_we), 0);
        chk(cur_upd == 1'b0, "R1", "cur_upd after reset", int'(cur_upd), 0);
        chk(rx_irq == 1'b0, "R1", "rx_irq after reset", int'(rx_irq), 0);
        chk(rx_status == 8'h00, "R1", "status after reset", int'(rx_status), 0);

        send(60, 1'b0, 5, -1, 1'b0, "R5");     // individual destination
        send(64, 1'b1, 9, -1, 1'b0, "R5");     // group destination, status 0x21
        chk(int'(cu) == 8'h42, "R8", "page after two short frames", int'(cu), 8'h42);
        send(248, 1'b0, 3, -1, 1'b0, "R8");    // exactly one page
        send(249, 1'b0, 4, -1, 1'b0, "R8");    // rounds up to two pages
        send(40, 1'b1, 7, -1, 1'b1, "R5");     // idle bubbles inside the frame

        // R6 wrap from the last page
        cu = 8'h5F; bd = 8'h50;
        send(300, 1'b0, 11, -1, 1'b0, "R6");
        chk(int'(cu) == 8'h41, "R6", "page after wrapped frame", int'(cu), 8'h41);

        // R2 stopped controller
        stopped = 1'b1;
        send(50, 1'b0, 1, -1, 1'b0, "R2");
        stopped = 1'b0;

        // R3 empty region
        sp = 8'h40;
        send(50, 1'b0, 2, -1, 1'b0, "R3");

        // R4 second branch: 2048 - 768 = 1280 drop, 2048 - 512 = 1536 accept
        st = 8'h40; sp = 8'h48; bd = 8'h40; cu = 8'h43;
        send(60, 1'b0, 21, -1, 1'b0, "R4");
        cu = 8'h42;
        send(60, 1'b0, 22, -1, 1'b0, "R4");
        // R4 first branch: 1280 drop, 1536 accept
        sp = 8'h60; cu = 8'h40; bd = 8'h45;
        send(60, 1'b0, 23, -1, 1'b0, "R4");
        bd = 8'h46;
        send(60, 1'b0, 24, -1, 1'b0, "R4");

        // R10 current page past packet memory
        cu = 8'h90; bd = 8'h7F;
        send(70, 1'b1, 31, -1, 1'b0, "R10");
        chk(int'(cu) == 8'h41, "R10", "page after restart", int'(cu), 8'h41);

        // R11 abandoned frame
        bd = 8'h40; cu = 8'h44;
        send(80, 1'b0, 41, 10, 1'b0, "R11");

        // R12 single-beat frame
        send(1, 1'b0, 51, -1, 1'b0, "R12");
        chk(int'(cu) == 8'h45, "R12", "page after one-byte frame", int'(cu), 8'h45);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule